// File: doc/BRIEF.md
# Priority Queue Request Selector

This block keeps pending memory requests in several queues, one per priority level. Each queued entry records only the rank it targets. In every cycle the block looks at the idle flags of all ranks and names one request to issue. It first finds the highest priority level that holds an eligible request. Inside that level it takes the oldest request whose rank is idle. Requests whose rank is busy are skipped, and they keep their place in age order.

The selection is presented combinationally as a found flag, the level, the entry's position within its level counted from the oldest, and the target rank. When the surrounding scheduler raises the issue strobe, the selected entry leaves its queue at the next clock edge. The entry may sit anywhere in the queue, and the younger entries behind it close the gap. In the same cycle one new request may be appended to the tail of any level.

Top module: `prio_req_sel`

## Requirements
- R1: After reset every level is empty and `sel_found_o` is low whatever the rank idle flags are.
- R2: Levels are searched from index NUM_PRIO-1 down to 0. The selected level is the highest one that holds at least one entry whose rank is idle.
- R3: Within the selected level the chosen entry is the oldest entry whose rank is idle. `sel_idx_o` is its position, where 0 is the oldest entry still queued. When all ranks are idle the chosen entry is always at position 0.
- R4: A level that holds a single entry whose rank is busy yields nothing, and the search moves on to lower levels. An empty level yields nothing.
- R5: When no level yields an entry, `sel_found_o` is low. A raised `issue_i` then changes no queue.
- R6: With `issue_i` high and `sel_found_o` high, the selected entry is removed at the next rising edge. The entries younger than it move up one position, and their relative order is kept.
- R7: With `enq_valid_i` high, an entry with rank `enq_rank_i` is appended at the tail of level `enq_prio_i`. This also holds when the same level loses an entry in the same cycle: both take effect, and the new entry becomes the youngest.
- R8: An enqueue to a level that already holds DEPTH entries, and that loses no entry in that cycle, is dropped.
- R9: The selection outputs follow `rank_idle_i` and the queue contents within the same cycle, with no register in between. With no issue and no enqueue, and the idle flags unchanged, they hold their values.
- R10: `sel_rank_o` is the rank of the selected entry, and that rank's bit in `rank_idle_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rank_idle_i | input | NUM_RANKS | Bit r set means rank r can accept a request |
| enq_valid_i | input | 1 | Append a new request this cycle |
| enq_prio_i | input | PRIO_W | Priority level of the new request |
| enq_rank_i | input | RANK_W | Target rank of the new request |
| issue_i | input | 1 | Remove the currently selected entry at the next edge |
| sel_found_o | output | 1 | An eligible entry is selected |
| sel_prio_o | output | PRIO_W | Level of the selected entry |
| sel_idx_o | output | IDX_W | Position of the selected entry in its level, 0 = oldest |
| sel_rank_o | output | RANK_W | Rank of the selected entry |

## Verification
A wrong compaction step or a wrong count in a level shows up at the ports one cycle after the faulty removal or enqueue. The next selection from that level then reports the wrong position or rank, or reports an entry that should be gone. A wrong scan order or age order is visible in the same cycle as a wrong level or position. The bench therefore compares every cycle against an independent model of all the queues, under many idle patterns. A dropped or duplicated entry shows up as soon as the selection reaches it.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

    // Bit width needed to index n items; never below one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/prio_sel_queue.sv
module prio_sel_queue #(
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned NUM_RANKS = 4,
    localparam int unsigned RANK_W   = prio_sel_pkg::width_of(NUM_RANKS),
    localparam int unsigned IDX_W    = prio_sel_pkg::width_of(DEPTH)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_RANKS-1:0] rank_idle_i,
    input  logic                 push_i,
    input  logic [RANK_W-1:0]    push_rank_i,
    input  logic                 pop_i,
    output logic                 cand_valid_o,
    output logic [IDX_W-1:0]     cand_idx_o,
    output logic [RANK_W-1:0]    cand_rank_o
);
    localparam int unsigned CNT_W = prio_sel_pkg::width_of(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][RANK_W-1:0] rank;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t q_d, q_q;

    // Oldest occupied slot whose rank is idle; the downward scan lets the lowest slot win.
    always_comb begin
        cand_valid_o = 1'b0;
        cand_idx_o   = '0;
        cand_rank_o  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(q_q.cnt) && rank_idle_i[q_q.rank[i]]) begin
                cand_valid_o = 1'b1;
                cand_idx_o   = IDX_W'(i);
                cand_rank_o  = q_q.rank[i];
            end
        end
    end

    // Next state: close the gap after a removal, then append at the new tail.
    always_comb begin
        logic [CNT_W-1:0] cnt_after;
        q_d       = q_q;
        cnt_after = q_q.cnt;
        if (pop_i && cand_valid_o) begin
            for (int j = 0; j < int'(DEPTH) - 1; j++) begin
                if (j >= int'(cand_idx_o)) begin
                    q_d.rank[j] = q_q.rank[j+1];
                end
            end
            cnt_after = q_q.cnt - 1'b1;
        end
        if (push_i && int'(cnt_after) < int'(DEPTH)) begin
            q_d.rank[cnt_after] = push_rank_i;
            q_d.cnt             = cnt_after + 1'b1;
        end else begin
            q_d.cnt = cnt_after;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/prio_sel_arb.sv
module prio_sel_arb #(
    parameter int unsigned NUM_PRIO = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned RANK_W   = 2,
    localparam int unsigned PRIO_W  = prio_sel_pkg::width_of(NUM_PRIO)
) (
    input  logic [NUM_PRIO-1:0]             cand_valid_i,
    input  logic [NUM_PRIO-1:0][IDX_W-1:0]  cand_idx_i,
    input  logic [NUM_PRIO-1:0][RANK_W-1:0] cand_rank_i,
    output logic                            found_o,
    output logic [PRIO_W-1:0]               prio_o,
    output logic [IDX_W-1:0]                idx_o,
    output logic [RANK_W-1:0]               rank_o,
    output logic [NUM_PRIO-1:0]             grant_o
);
    // Ascending scan overwrites, so the highest level with a candidate wins.
    always_comb begin
        found_o = 1'b0;
        prio_o  = '0;
        idx_o   = '0;
        rank_o  = '0;
        grant_o = '0;
        for (int p = 0; p < int'(NUM_PRIO); p++) begin
            if (cand_valid_i[p]) begin
                found_o    = 1'b1;
                prio_o     = PRIO_W'(p);
                idx_o      = cand_idx_i[p];
                rank_o     = cand_rank_i[p];
                grant_o    = '0;
                grant_o[p] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_req_sel.sv
module prio_req_sel #(
    parameter int unsigned NUM_PRIO  = 4,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned NUM_RANKS = 4,
    localparam int unsigned PRIO_W   = prio_sel_pkg::width_of(NUM_PRIO),
    localparam int unsigned RANK_W   = prio_sel_pkg::width_of(NUM_RANKS),
    localparam int unsigned IDX_W    = prio_sel_pkg::width_of(DEPTH)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_RANKS-1:0] rank_idle_i,
    input  logic                 enq_valid_i,
    input  logic [PRIO_W-1:0]    enq_prio_i,
    input  logic [RANK_W-1:0]    enq_rank_i,
    input  logic                 issue_i,
    output logic                 sel_found_o,
    output logic [PRIO_W-1:0]    sel_prio_o,
    output logic [IDX_W-1:0]     sel_idx_o,
    output logic [RANK_W-1:0]    sel_rank_o
);
    logic [NUM_PRIO-1:0]             cand_valid;
    logic [NUM_PRIO-1:0][IDX_W-1:0]  cand_idx;
    logic [NUM_PRIO-1:0][RANK_W-1:0] cand_rank;
    logic [NUM_PRIO-1:0]             grant;

    for (genvar g = 0; g < NUM_PRIO; g++) begin : g_level
        logic push, pop;
        assign push = enq_valid_i && (int'(enq_prio_i) == g);
        assign pop  = issue_i && grant[g];

        prio_sel_queue #(
            .DEPTH     (DEPTH),
            .NUM_RANKS (NUM_RANKS)
        ) level_q_i (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .rank_idle_i  (rank_idle_i),
            .push_i       (push),
            .push_rank_i  (enq_rank_i),
            .pop_i        (pop),
            .cand_valid_o (cand_valid[g]),
            .cand_idx_o   (cand_idx[g]),
            .cand_rank_o  (cand_rank[g])
        );
    end

    prio_sel_arb #(
        .NUM_PRIO (NUM_PRIO),
        .IDX_W    (IDX_W),
        .RANK_W   (RANK_W)
    ) arb_i (
        .cand_valid_i (cand_valid),
        .cand_idx_i   (cand_idx),
        .cand_rank_i  (cand_rank),
        .found_o      (sel_found_o),
        .prio_o       (sel_prio_o),
        .idx_o        (sel_idx_o),
        .rank_o       (sel_rank_o),
        .grant_o      (grant)
    );

endmodule

// File: rtl/prio_req_sel_chk.sv
module prio_req_sel_chk #(
    parameter int unsigned NUM_PRIO  = 4,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned NUM_RANKS = 4,
    localparam int unsigned PRIO_W   = prio_sel_pkg::width_of(NUM_PRIO),
    localparam int unsigned RANK_W   = prio_sel_pkg::width_of(NUM_RANKS),
    localparam int unsigned IDX_W    = prio_sel_pkg::width_of(DEPTH)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_RANKS-1:0] rank_idle_i,
    input logic                 enq_valid_i,
    input logic                 issue_i,
    input logic                 sel_found_o,
    input logic [PRIO_W-1:0]    sel_prio_o,
    input logic [IDX_W-1:0]     sel_idx_o,
    input logic [RANK_W-1:0]    sel_rank_o
);
    // R10: the reported rank must be idle
    assert_idle_rank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_found_o |-> rank_idle_i[sel_rank_o]);

    // R5: nothing can be eligible while every rank is busy
    assert_all_busy_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rank_idle_i == '0) |-> !sel_found_o);

    // R3: with all ranks idle the oldest entry of the level is taken
    assert_all_idle_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&rank_idle_i) && sel_found_o) |-> (sel_idx_o == '0));

    // R9: a quiet cycle with unchanged idle flags keeps the selection
    assert_quiet_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!issue_i && !enq_valid_i) ##1 $stable(rank_idle_i) |->
            ($stable(sel_found_o) && $stable(sel_prio_o) &&
             $stable(sel_idx_o) && $stable(sel_rank_o)));

endmodule

bind prio_req_sel prio_req_sel_chk #(
    .NUM_PRIO  (NUM_PRIO),
    .DEPTH     (DEPTH),
    .NUM_RANKS (NUM_RANKS)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rank_idle_i (rank_idle_i),
    .enq_valid_i (enq_valid_i),
    .issue_i     (issue_i),
    .sel_found_o (sel_found_o),
    .sel_prio_o  (sel_prio_o),
    .sel_idx_o   (sel_idx_o),
    .sel_rank_o  (sel_rank_o)
);

// File: tb/prio_req_sel_tb_top.sv
module prio_req_sel_tb_top;
    localparam int NP = 4;
    localparam int DP = 4;
    localparam int NR = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [NR-1:0] rank_idle_i = '0;
    logic          enq_valid_i = 1'b0;
    logic [1:0]    enq_prio_i = '0;
    logic [1:0]    enq_rank_i = '0;
    logic          issue_i = 1'b0;
    logic          sel_found_o;
    logic [1:0]    sel_prio_o;
    logic [1:0]    sel_idx_o;
    logic [1:0]    sel_rank_o;

    int checks = 0;
    int fails  = 0;
    int mr [NP][DP];
    int mc [NP];

    always #5 clk_i = ~clk_i;

    prio_req_sel #(.NUM_PRIO(NP), .DEPTH(DP), .NUM_RANKS(NR)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .rank_idle_i(rank_idle_i),
        .enq_valid_i(enq_valid_i), .enq_prio_i(enq_prio_i), .enq_rank_i(enq_rank_i),
        .issue_i(issue_i), .sel_found_o(sel_found_o), .sel_prio_o(sel_prio_o),
        .sel_idx_o(sel_idx_o), .sel_rank_o(sel_rank_o)
    );

    function automatic void model_pick(input logic [NR-1:0] idle, output bit f,
                                       output int p, output int ix, output int r);
        f = 0; p = 0; ix = 0; r = 0;
        for (int lv = NP - 1; lv >= 0; lv--) begin
            for (int i = 0; i < mc[lv]; i++) begin
                if (!f && idle[mr[lv][i]]) begin
                    f = 1; p = lv; ix = i; r = mr[lv][i];
                end
            end
            if (f) break;
        end
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit ev, input int ep, input int er, input bit iss,
                        input logic [NR-1:0] idle, input string tag);
        bit f; int p, ix, r;
        @(negedge clk_i);
        enq_valid_i = ev; enq_prio_i = 2'(ep); enq_rank_i = 2'(er);
        issue_i = iss; rank_idle_i = idle;
        #1;
        model_pick(idle, f, p, ix, r);
        check(tag, "found", int'(sel_found_o), int'(f));
        if (f) begin
            check(tag, "prio", int'(sel_prio_o), p);
            check(tag, "idx", int'(sel_idx_o), ix);
            check(tag, "rank", int'(sel_rank_o), r);
        end
        if (iss && f) begin
            for (int i = ix; i < mc[p] - 1; i++) mr[p][i] = mr[p][i+1];
            mc[p]--;
        end
        if (ev && mc[ep] < DP) begin
            mr[ep][mc[ep]] = er;
            mc[ep]++;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) mc[p] = 0;
        repeat (3) @(posedge clk_i);
        #2 rst_ni = 1'b1;
        // R1: empty after reset
        step(0, 0, 0, 1, 4'hF, "R1");
        // R4: lone entry on a busy rank is skipped
        step(1, 3, 0, 0, 4'h0, "R4");
        step(0, 0, 0, 0, 4'b1110, "R4");
        step(1, 1, 2, 0, 4'b1110, "R4");
        step(0, 0, 0, 0, 4'b1110, "R4");
        // R3: oldest idle entry inside a level
        step(1, 2, 1, 0, 4'h0, "R3");
        step(1, 2, 3, 0, 4'h0, "R3");
        step(1, 2, 1, 0, 4'h0, "R3");
        step(0, 0, 0, 0, 4'b1000, "R3");
        // R6: removal from the middle, then order of the rest
        step(0, 0, 0, 1, 4'b1000, "R6");
        step(0, 0, 0, 0, 4'b0010, "R6");
        step(0, 0, 0, 1, 4'b0010, "R6");
        step(0, 0, 0, 0, 4'b0010, "R6");
        // R2: highest level wins when several qualify
        step(0, 0, 0, 0, 4'hF, "R2");
        // R5: issue with nothing eligible changes nothing
        step(0, 0, 0, 1, 4'h0, "R5");
        step(0, 0, 0, 0, 4'b0100, "R5");
        // R7: enqueue and removal on the same level together
        step(1, 2, 0, 1, 4'b0010, "R7");
        step(0, 0, 0, 0, 4'b0001, "R7");
        // R8: overfilling a level drops the extra request
        for (int k = 0; k < DP + 2; k++) step(1, 0, k % NR, 0, 4'h0, "R8");
        for (int k = 0; k < 12; k++) step(0, 0, 0, 1, 4'hF, "R8");
        step(0, 0, 0, 0, 4'hF, "R8");
        // R9/R10: constrained random traffic, selection checked every cycle
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 600; k++) begin
            step(($urandom % 3) != 0, $urandom % NP, $urandom % NR,
                 ($urandom % 2) == 0, 4'($urandom), "R9");
        end
        // R6: drain
        for (int k = 0; k < 20; k++) step(0, 0, 0, 1, 4'hF, "R6");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule